// File: doc/BRIEF.md
# Quiz Buzzer Arbiter with Decimal Countdown

This block referees a four-seat quiz round. After a host reset it waits in an idle state showing a full answer window of sixty seconds and an empty winner code. When the host asserts the start input, a two-digit decimal countdown begins. It steps down once for every pulse of a one-second tick enable that the surrounding chip supplies. The first contestant whose button is seen high while the countdown runs wins the round. The block freezes that contestant's number, reloads the timer to sixty, and stays locked until the next host reset. If the window runs out with nobody pressing, the block drops back to idle and reloads the timer, ready for another start.

Contestant buttons arrive already synchronous and clean. The tick is a single-cycle enable. The digits and the winner code are plain BCD values, and a display driver elsewhere turns them into segments. The state machine has three states: IDLE, COUNT and LOCKED. Its transitions are:
- IDLE to COUNT, named "start".
- COUNT to LOCKED, named "buzz".
- COUNT to IDLE, named "expire".
- LOCKED to LOCKED, named "hold".

Every other case keeps the current state.

Top module: `buzz_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, the outputs read `tens_o`=6, `units_o`=0, `code_o`=0, `locked_o`=0 and `busy_o`=0.
- R2: When `start_i` is high in IDLE, `busy_o` rises after the next clock edge and the timer still reads 60. `start_i` has no effect in COUNT or LOCKED.
- R3: In IDLE, button presses and ticks change nothing: `code_o` stays 0, `locked_o` stays 0 and the timer stays 60.
- R4: In COUNT, each cycle with `tick_i` high and no button pressed lowers the timer by one. When the units digit is 0 it wraps to 9 and the tens digit drops by one, so the timer reads 60, 59, ... 01, 00. Cycles without a tick leave the timer unchanged.
- R5: Any button high in COUNT causes a buzz. After the next edge `locked_o`=1, `busy_o`=0, `code_o` holds the winner's number, and the timer reads 60 again.
- R6: Button bit 0 is contestant 1 and bit 3 is contestant 4, so the code is the bit index plus one. When several buttons are high in the same cycle, the lowest-numbered contestant wins.
- R7: A tick in COUNT while the timer reads 00, with no button high, expires the round. After the next edge the block is in IDLE (`busy_o`=0, `locked_o`=0) and the timer reads 60.
- R8: If a button is high in the same cycle as the expiring tick, the buzz wins and the block locks instead of going to IDLE.
- R9: In LOCKED, buttons, `start_i` and `tick_i` have no effect. `code_o` and the timer stay fixed, and only `rst_n` leaves the state.
- R10: `busy_o` and `locked_o` are never high together. The digits always stay BCD: `units_o` is at most 9 and `tens_o` is at most 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low host reset |
| start_i | input | 1 | Host start request |
| tick_i | input | 1 | One-cycle enable, once per second |
| btn_i | input | 4 | Contestant buttons, bit 0 = contestant 1 |
| tens_o | output | 4 | Countdown tens digit, BCD |
| units_o | output | 4 | Countdown units digit, BCD |
| code_o | output | 4 | Winning contestant number, BCD, 0 when none |
| locked_o | output | 1 | High in LOCKED |
| busy_o | output | 1 | High in COUNT |

## Verification
A wrong state register shows up on `busy_o` and `locked_o` in the cycle after the faulty transition. It also shows up in a timer that moves while idle or locked, or that fails to reload to 60 after a buzz or an expiry. A faulty priority or capture path shows up in `code_o` one edge after the buzz. A broken borrow shows up at the first tick taken from a units digit of 0, so the first wrap from 60 to 59 already reveals it. Every cycle the bench compares all outputs against a model built from the requirements, so any divergence is reported in the cycle it appears.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
    parameter int NUM_SEATS = 4;
    parameter int DIGIT_W   = 4;
    parameter int START_TEN = 6;
    parameter int START_ONE = 0;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_LOCKED = 2'd2
    } round_state_t;
endpackage

// File: rtl/buzz_priority.sv
module buzz_priority #(
    parameter int SEATS  = buzz_pkg::NUM_SEATS,
    parameter int CODE_W = buzz_pkg::DIGIT_W
) (
    input  logic [SEATS-1:0]  req_i,
    output logic              hit_o,
    output logic [CODE_W-1:0] code_o
);
    logic [SEATS-1:0] grant;

    // one-hot grant: a seat wins only when every lower seat is quiet
    generate
        for (genvar g = 0; g < SEATS; g++) begin : g_grant
            if (g == 0) begin : g_first
                assign grant[g] = req_i[g];
            end else begin : g_rest
                assign grant[g] = req_i[g] & ~(|req_i[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        code_o = '0;
        for (int s = 0; s < SEATS; s++) begin
            if (grant[s]) begin
                code_o = code_o | CODE_W'(s + 1);
            end
        end
    end

    assign hit_o = |req_i;
endmodule

// File: rtl/buzz_bcd_timer.sv
module buzz_bcd_timer #(
    parameter int DW        = buzz_pkg::DIGIT_W,
    parameter int INIT_TEN  = buzz_pkg::START_TEN,
    parameter int INIT_ONE  = buzz_pkg::START_ONE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload_i,
    input  logic          step_i,
    output logic [DW-1:0] tens_o,
    output logic [DW-1:0] units_o,
    output logic          zero_o
);
    localparam logic [DW-1:0] TEN_LOAD = DW'(INIT_TEN);
    localparam logic [DW-1:0] ONE_LOAD = DW'(INIT_ONE);
    localparam logic [DW-1:0] ONE_TOP  = DW'(9);

    logic [DW-1:0] tens_q, units_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tens_q  <= TEN_LOAD;
            units_q <= ONE_LOAD;
        end else if (reload_i) begin
            tens_q  <= TEN_LOAD;
            units_q <= ONE_LOAD;
        end else if (step_i) begin
            if (units_q == '0) begin
                units_q <= ONE_TOP;
                tens_q  <= tens_q - DW'(1);
            end else begin
                units_q <= units_q - DW'(1);
            end
        end
    end

    assign tens_o  = tens_q;
    assign units_o = units_q;
    assign zero_o  = (tens_q == '0) && (units_q == '0);
endmodule

// File: rtl/buzz_round_fsm.sv
module buzz_round_fsm
    import buzz_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         tick_i,
    input  logic         hit_i,
    input  logic         zero_i,
    output round_state_t state_o,
    output logic         reload_o,
    output logic         step_o,
    output logic         capture_o
);
    round_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_COUNT;           // start
            end
            ST_COUNT: begin
                if (hit_i)                  state_d = ST_LOCKED; // buzz
                else if (tick_i && zero_i)  state_d = ST_IDLE;   // expire
            end
            ST_LOCKED: state_d = ST_LOCKED;                 // hold
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        reload_o  = 1'b0;
        step_o    = 1'b0;
        capture_o = 1'b0;
        unique case (state_q)
            ST_COUNT: begin
                capture_o = hit_i;
                reload_o  = hit_i || (tick_i && zero_i);
                step_o    = !hit_i && tick_i && !zero_i;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/buzz_arbiter.sv
module buzz_arbiter
    import buzz_pkg::*;
#(
    parameter int SEATS = NUM_SEATS,
    parameter int DW    = DIGIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic [SEATS-1:0] btn_i,
    output logic [DW-1:0]    tens_o,
    output logic [DW-1:0]    units_o,
    output logic [DW-1:0]    code_o,
    output logic             locked_o,
    output logic             busy_o
);
    logic          hit, zero, reload, step, capture;
    logic [DW-1:0] prio_code, code_q;
    round_state_t  state;

    buzz_priority #(.SEATS(SEATS), .CODE_W(DW)) u_prio (
        .req_i  (btn_i),
        .hit_o  (hit),
        .code_o (prio_code)
    );

    buzz_round_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .tick_i    (tick_i),
        .hit_i     (hit),
        .zero_i    (zero),
        .state_o   (state),
        .reload_o  (reload),
        .step_o    (step),
        .capture_o (capture)
    );

    buzz_bcd_timer #(.DW(DW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (reload),
        .step_i   (step),
        .tens_o   (tens_o),
        .units_o  (units_o),
        .zero_o   (zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       code_q <= '0;
        else if (capture) code_q <= prio_code;
    end

    assign code_o   = code_q;
    assign locked_o = (state == ST_LOCKED);
    assign busy_o   = (state == ST_COUNT);
endmodule

// File: rtl/buzz_arbiter_chk.sv
module buzz_arbiter_chk #(
    parameter int SEATS = buzz_pkg::NUM_SEATS,
    parameter int DW    = buzz_pkg::DIGIT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             tick_i,
    input logic [SEATS-1:0] btn_i,
    input logic [DW-1:0]    tens_o,
    input logic [DW-1:0]    units_o,
    input logic [DW-1:0]    code_o,
    input logic             locked_o,
    input logic             busy_o
);
    a_r2_start_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !locked_o && start_i) |=> busy_o);

    a_r3_idle_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !locked_o) |-> (code_o == '0));

    a_r4_steady_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick_i && (btn_i == '0)) |=> ($stable(tens_o) && $stable(units_o)));

    a_r5_buzz_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (btn_i != '0)) |=> locked_o);

    a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> (locked_o && $stable(code_o) && $stable(tens_o)));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_o, locked_o}));

    a_r10_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
        (units_o <= DW'(9)) && (tens_o <= DW'(6)));
endmodule

bind buzz_arbiter buzz_arbiter_chk #(.SEATS(SEATS), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .tick_i   (tick_i),
    .btn_i    (btn_i),
    .tens_o   (tens_o),
    .units_o  (units_o),
    .code_o   (code_o),
    .locked_o (locked_o),
    .busy_o   (busy_o)
);

// File: tb/buzz_arbiter_tb.sv
`timescale 1ns/1ps
module buzz_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       tick_i = 1'b0;
    logic [3:0] btn_i = 4'h0;
    logic [3:0] tens_o, units_o, code_o;
    logic       locked_o, busy_o;

    int errors = 0;
    int checks = 0;

    // model: 0 idle, 1 counting, 2 locked
    int         m_st = 0;
    logic [3:0] m_ten = 4'd6, m_one = 4'd0, m_code = 4'd0;

    always #10 clk = ~clk;

    buzz_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
        .btn_i(btn_i), .tens_o(tens_o), .units_o(units_o), .code_o(code_o),
        .locked_o(locked_o), .busy_o(busy_o)
    );

    function automatic logic [3:0] exp_winner(input logic [3:0] b);
        for (int s = 0; s < 4; s++) if (b[s]) return 4'(s + 1);
        return 4'd0;
    endfunction

    function automatic logic [7:0] exp_step(input logic [3:0] t, input logic [3:0] u);
        if (u == 4'd0) return {t - 4'd1, 4'd9};
        return {t, u - 4'd1};
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tens_o == m_ten,   {tag, " tens"},  tens_o,  m_ten);
        check(units_o == m_one,  {tag, " units"}, units_o, m_one);
        check(code_o == m_code,  {tag, " code"},  code_o,  m_code);
        check(busy_o == (m_st == 1),   {tag, " busy"},   busy_o,   m_st == 1);
        check(locked_o == (m_st == 2), {tag, " locked"}, locked_o, m_st == 2);
        check(units_o <= 4'd9 && tens_o <= 4'd6, "R10 bcd range", {tens_o, units_o}, 96);
    endtask

    task automatic model_reset();
        m_st = 0; m_ten = 4'd6; m_one = 4'd0; m_code = 4'd0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start_i = 0; tick_i = 0; btn_i = 0;
        repeat (2) @(posedge clk);
        #1;
        model_reset();
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_all("R1 after reset");
    endtask

    task automatic cyc(input logic st, input logic tk, input logic [3:0] b, input string tag);
        start_i = st; tick_i = tk; btn_i = b;
        @(posedge clk);
        if (m_st == 0) begin
            if (st) m_st = 1;
        end else if (m_st == 1) begin
            if (b != 4'd0) begin
                m_st = 2; m_code = exp_winner(b); m_ten = 4'd6; m_one = 4'd0;
            end else if (tk) begin
                if (m_ten == 0 && m_one == 0) begin
                    m_st = 0; m_ten = 4'd6; m_one = 4'd0;
                end else begin
                    {m_ten, m_one} = exp_step(m_ten, m_one);
                end
            end
        end
        #1;
        check_all(tag);
    endtask

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        do_reset();

        // R3: idle ignores presses and ticks
        cyc(0, 1, 4'hF, "R3 idle press");
        cyc(0, 1, 4'h4, "R3 idle press");
        // R2: start, and start again is ignored
        cyc(1, 0, 4'h0, "R2 start");
        cyc(1, 0, 4'h0, "R2 start in count");
        // R4: borrow 60->59 and onward, gaps without tick
        for (int k = 0; k < 12; k++) cyc(0, 1'(k % 3 != 2), 4'h0, "R4 countdown");
        // R6/R5: tie of contestants 2,3,4 -> 2
        cyc(0, 1, 4'b1110, "R5 R6 tie buzz");
        check(code_o == 4'd2, "R6 tie winner", code_o, 2);
        // R9: locked ignores all
        cyc(0, 1, 4'b0001, "R9 locked press");
        cyc(1, 1, 4'b1111, "R9 locked start");
        cyc(0, 0, 4'b1000, "R9 locked idle");

        // R7: full expiry
        do_reset();
        cyc(1, 0, 4'h0, "R2 start");
        for (int k = 0; k < 60; k++) cyc(0, 1, 4'h0, "R4 full run");
        check(tens_o == 0 && units_o == 0, "R4 reaches 00", {tens_o, units_o}, 0);
        cyc(0, 1, 4'h0, "R7 expire");
        check(!busy_o && !locked_o && tens_o == 6, "R7 idle again", busy_o, 0);
        // R8: press on the expiring tick locks
        cyc(1, 0, 4'h0, "R2 restart");
        for (int k = 0; k < 60; k++) cyc(0, 1, 4'h0, "R4 second run");
        cyc(0, 1, 4'b1000, "R8 press on final tick");
        check(locked_o && code_o == 4'd4, "R8 lock wins", code_o, 4);

        // single contestant codes, R6
        for (int s = 0; s < 4; s++) begin
            do_reset();
            cyc(1, 0, 4'h0, "R2 start");
            cyc(0, 0, 4'(1 << s), "R6 single seat");
        end

        // constrained random
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            logic st, tk;
            logic [3:0] b;
            if (($urandom % 500) == 0) begin
                do_reset();
            end else begin
                st = (($urandom % 8) == 0);
                tk = (($urandom % 2) == 0);
                b  = (($urandom % 40) == 0) ? 4'($urandom) : 4'h0;
                cyc(st, tk, b, "R4 R5 R6 R7 R9 random");
            end
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule